// File: doc/BRIEF.md
# Multifunction Pin Controller

This block drives seven shared pins, each of which can serve as a receive-path input, an indicator for a chosen group of DAC channel mutes, an ADC overflow indicator, or a fixed high output. Each pin has its own control byte, given to the block as parallel data. The byte holds a two-bit mode, a polarity bit and five channel-select bits. The block turns each byte into an output value and an output-enable for its pin. It also resolves which line feeds the receiver input multiplexer.

The control bytes, the DAC mute flags and the ADC overflow flag are registered on entry. The pad outputs are therefore a simple function of one set of sampled state. The overflow flag is caught in a sticky latch. A single-cycle overflow then stays visible on any overflow-mode pin until software clears the latch. The receiver selector accepts a pin only if that pin is currently configured as an input. Otherwise it falls back to the dedicated receive line.

Top module: `gp_pin_ctrl`

## Requirements
- R1: Pin p takes its settings from byte p of `pin_cfg_i`. Bits [8p+7:8p+6] hold the mode (00 input, 01 mute, 10 overflow, 11 high), bit 8p+5 holds the polarity and bits [8p+4:8p] hold the channel selects. A new setting reaches the outputs one clock after it is applied.
- R2: In mode 00 the pin has `pin_oe_o` low and `pin_out_o` low.
- R3: In mode 01 the pin is driven. Its value is the OR of the muted selected channels, XORed with the polarity bit. Select bit f of pin p picks DAC channel (p+f) mod 8. Mute flags reach the pin one clock after they are applied.
- R4: In mode 01 with all five select bits clear, the pin is driven to the polarity bit whatever the mute flags are.
- R5: In mode 10 the pin is driven to the overflow latch XORed with the polarity bit.
- R6: The overflow latch sets one clock after `adc_ovf_i` is high. It holds until a cycle in which `ovf_clr_i` is high and `adc_ovf_i` is low. A set in the same cycle as a clear wins.
- R7: In mode 11 the pin is driven high whatever the polarity bit is.
- R8: While `rst_ni` is low, and after release until a setting is captured, every pin has output-enable low and output low, and the overflow latch is clear.
- R9: A `rx_sel_i` of 0 selects `rx0_i`. A value k from 1 to 7 selects pin k-1 only if that pin is in mode 00. In any other case the selection falls back to 0. `rx_idx_o` reports the resulting index and `rx_data_o` carries that line's live level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_cfg_i | input | 56 | Seven control bytes, byte p for pin p |
| dac_mute_i | input | 8 | Mute flag for each DAC channel |
| adc_ovf_i | input | 1 | ADC overflow flag |
| ovf_clr_i | input | 1 | Clears the overflow latch |
| pin_in_i | input | 7 | Levels read back from the seven pins |
| rx0_i | input | 1 | Dedicated receiver input line |
| rx_sel_i | input | 3 | Requested receiver source index |
| pin_out_o | output | 7 | Value driven on each pin |
| pin_oe_o | output | 7 | Output-enable for each pin |
| rx_idx_o | output | 3 | Receiver source index in effect |
| rx_data_o | output | 1 | Level of the selected receiver source |

## Verification
The hardest case to reach is a same-cycle clash on the overflow latch. A one-cycle overflow must still show, and a clear that arrives together with a new overflow must lose. This is reached only by driving `adc_ovf_i` and `ovf_clr_i` in carefully timed pulses while pins of both polarities sit in overflow mode. A directed phase builds exactly that sequence. A long mixed phase then rotates modes, channel selects, mute patterns and receiver requests, including requests for pins that are being driven. A behavioural model predicts every pin and the receiver outputs on each clock.

// File: rtl/gpp_pkg.sv
package gpp_pkg;
  localparam int FN_W = 5;

  typedef enum logic [1:0] {
    GP_RX   = 2'b00,
    GP_MUTE = 2'b01,
    GP_OVF  = 2'b10,
    GP_HIGH = 2'b11
  } gp_mode_e;

  typedef struct packed {
    gp_mode_e         mode;
    logic             inv;
    logic [FN_W-1:0]  fsel;
  } gp_cfg_t;

  localparam int CFG_W = $bits(gp_cfg_t);

  // channel wired to select bit f of pin p
  function automatic int chan_of(int p, int f, int nch);
    return (p + f) % nch;
  endfunction
endpackage

// File: rtl/gpp_ovf_latch.sv
module gpp_ovf_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_OVF_SET:  assert property (@(posedge clk_i) disable iff (!rst_ni) set_i |=> flag_o); // R6
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (flag_o && !clr_i) |=> flag_o); // R6
  AST_OVF_CLR:  assert property (@(posedge clk_i) disable iff (!rst_ni) (clr_i && !set_i) |=> !flag_o); // R6
endmodule

// File: rtl/gpp_pin_slice.sv
module gpp_pin_slice
  import gpp_pkg::*;
#(
  parameter int PIN    = 0,
  parameter int NUM_CH = 8
) (
  input  gp_cfg_t            cfg_i,
  input  logic [NUM_CH-1:0]  mute_i,
  input  logic               ovf_i,
  output logic               out_o,
  output logic               oe_o
);
  logic [FN_W-1:0] sel_mute;

  for (genvar f = 0; f < FN_W; f++) begin : g_map
    localparam int CH = chan_of(PIN, f, NUM_CH);
    assign sel_mute[f] = mute_i[CH];
  end

  logic any_mute;
  assign any_mute = |(sel_mute & cfg_i.fsel);

  always_comb begin
    out_o = 1'b0;
    oe_o  = 1'b1;
    unique case (cfg_i.mode)
      GP_RX:   oe_o  = 1'b0;
      GP_MUTE: out_o = any_mute ^ cfg_i.inv;
      GP_OVF:  out_o = ovf_i ^ cfg_i.inv;
      GP_HIGH: out_o = 1'b1;
      default: oe_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpp_rx_sel.sv
module gpp_rx_sel #(
  parameter int NUM_PINS = 7,
  localparam int SEL_W   = $clog2(NUM_PINS + 1)
) (
  input  logic [SEL_W-1:0]    rx_sel_i,
  input  logic [NUM_PINS-1:0] rx_ok_i,
  input  logic [NUM_PINS-1:0] pin_in_i,
  input  logic                rx0_i,
  output logic [SEL_W-1:0]    idx_o,
  output logic                data_o
);
  always_comb begin
    idx_o  = '0;
    data_o = rx0_i;
    for (int k = 0; k < NUM_PINS; k++) begin
      if (rx_sel_i == SEL_W'(k + 1) && rx_ok_i[k]) begin
        idx_o  = SEL_W'(k + 1);
        data_o = pin_in_i[k];
      end
    end
  end
endmodule

// File: rtl/gp_pin_ctrl.sv
module gp_pin_ctrl
  import gpp_pkg::*;
#(
  parameter int NUM_PINS = 7,
  parameter int NUM_CH   = 8,
  localparam int SEL_W   = $clog2(NUM_PINS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS*CFG_W-1:0] pin_cfg_i,
  input  logic [NUM_CH-1:0]         dac_mute_i,
  input  logic                      adc_ovf_i,
  input  logic                      ovf_clr_i,
  input  logic [NUM_PINS-1:0]       pin_in_i,
  input  logic                      rx0_i,
  input  logic [SEL_W-1:0]          rx_sel_i,
  output logic [NUM_PINS-1:0]       pin_out_o,
  output logic [NUM_PINS-1:0]       pin_oe_o,
  output logic [SEL_W-1:0]          rx_idx_o,
  output logic                      rx_data_o
);
  gp_cfg_t              cfg_q [NUM_PINS];
  logic [NUM_CH-1:0]    mute_q;
  logic                 ovf_flag;
  logic [NUM_PINS-1:0]  rx_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= '0;
      mute_q <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= gp_cfg_t'(pin_cfg_i[i*CFG_W +: CFG_W]);
      mute_q <= dac_mute_i;
    end
  end

  gpp_ovf_latch u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (adc_ovf_i),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_flag)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpp_pin_slice #(.PIN(p), .NUM_CH(NUM_CH)) u_slice (
      .cfg_i  (cfg_q[p]),
      .mute_i (mute_q),
      .ovf_i  (ovf_flag),
      .out_o  (pin_out_o[p]),
      .oe_o   (pin_oe_o[p])
    );
    assign rx_ok[p] = (cfg_q[p].mode == GP_RX);

    AST_RX_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_cfg_i[p*CFG_W+6 +: 2] == 2'b00) |=> (!pin_oe_o[p] && !pin_out_o[p])); // R2
    AST_NOMAP_POL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_cfg_i[p*CFG_W+6 +: 2] == 2'b01 && pin_cfg_i[p*CFG_W +: FN_W] == '0)
      |=> (pin_oe_o[p] && pin_out_o[p] == $past(pin_cfg_i[p*CFG_W+5]))); // R4
    AST_OVF_SHOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_cfg_i[p*CFG_W+6 +: 2] == 2'b10 && adc_ovf_i)
      |=> (pin_oe_o[p] && pin_out_o[p] == !$past(pin_cfg_i[p*CFG_W+5]))); // R5
    AST_HIGH_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_cfg_i[p*CFG_W+6 +: 2] == 2'b11) |=> (pin_oe_o[p] && pin_out_o[p])); // R7
    AST_RX_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_idx_o == SEL_W'(p + 1)) |-> (!pin_oe_o[p] && rx_data_o == pin_in_i[p])); // R9
  end

  gpp_rx_sel #(.NUM_PINS(NUM_PINS)) u_rx (
    .rx_sel_i (rx_sel_i),
    .rx_ok_i  (rx_ok),
    .pin_in_i (pin_in_i),
    .rx0_i    (rx0_i),
    .idx_o    (rx_idx_o),
    .data_o   (rx_data_o)
  );
endmodule

// File: tb/sim_gp_pin_ctrl.sv
module sim_gp_pin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [55:0] cfg = '0;
  logic [7:0]  mute = '0;
  logic        ovf = 1'b0, clr = 1'b0, rx0 = 1'b0;
  logic [6:0]  pin_in = '0;
  logic [2:0]  rx_sel = '0;
  logic [6:0]  pin_out, pin_oe;
  logic [2:0]  rx_idx;
  logic        rx_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  bit [55:0] cfg_m;
  bit [7:0]  mute_m;
  bit        ovf_m;

  always #2 clk = ~clk;

  gp_pin_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_cfg_i(cfg), .dac_mute_i(mute),
    .adc_ovf_i(ovf), .ovf_clr_i(clr), .pin_in_i(pin_in), .rx0_i(rx0),
    .rx_sel_i(rx_sel), .pin_out_o(pin_out), .pin_oe_o(pin_oe),
    .rx_idx_o(rx_idx), .rx_data_o(rx_data)
  );

  function automatic int mode_of(int p);
    return int'(cfg_m[8*p+6 +: 2]);
  endfunction

  function automatic bit exp_out(int p);
    bit pol = cfg_m[8*p+5];
    bit any = 0;
    case (mode_of(p))
      0: return 1'b0;
      1: begin
        for (int f = 0; f < 5; f++)
          if (cfg_m[8*p+f] && mute_m[(p+f)%8]) any = 1;
        return any ^ pol;
      end
      2: return ovf_m ^ pol;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag_of(int p);
    if (!rst_n) return "R8";
    case (mode_of(p))
      0: return "R2";
      1: return (cfg_m[8*p +: 5] == 0) ? "R4" : "R3";
      2: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int  ei;
    bit  ed;
    for (int p = 0; p < 7; p++) begin
      chk(tag_of(p), $sformatf("oe[%0d]", p), int'(pin_oe[p]), int'(mode_of(p) != 0));
      chk(tag_of(p), $sformatf("out[%0d]", p), int'(pin_out[p]), int'(exp_out(p)));
    end
    ei = 0; ed = rx0;
    if (rx_sel != 0 && mode_of(int'(rx_sel) - 1) == 0) begin
      ei = int'(rx_sel); ed = pin_in[int'(rx_sel) - 1];
    end
    chk("R9", "rx_idx", int'(rx_idx), ei);
    chk("R9", "rx_data", int'(rx_data), int'(ed));
  endtask

  // model state advances on the edge from inputs held since the last falling edge (R1, R6)
  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      cfg_m = '0; mute_m = '0; ovf_m = 0;
    end else begin
      cfg_m  = cfg;
      mute_m = mute;
      ovf_m  = ovf | (ovf_m & ~clr);
    end
    @(negedge clk);
    compare();
  endtask

  function automatic logic [7:0] byte_of(int mode, bit pol, int fn);
    return {2'(mode), pol, 5'(fn)};
  endfunction

  initial begin
    // R8: reset with busy inputs
    cfg = {7{8'hFF}}; mute = '1; ovf = 1; rx_sel = 3; pin_in = '1;
    repeat (5) step();
    rst_n = 1; ovf = 0;
    // R7: all pins high, both polarities
    for (int p = 0; p < 7; p++) cfg[8*p +: 8] = byte_of(3, p[0], p);
    repeat (3) step();
    // R3: one select bit per pin, walk one muted channel
    for (int b = 0; b < 5; b++) begin
      for (int p = 0; p < 7; p++) cfg[8*p +: 8] = byte_of(1, p[1], 1 << b);
      for (int c = 0; c < 8; c++) begin mute = 8'(1 << c); step(); end
    end
    // R4: nothing selected, mutes active
    for (int p = 0; p < 7; p++) cfg[8*p +: 8] = byte_of(1, p[0], 0);
    mute = '1; repeat (3) step();
    // R6/R5: single-cycle overflow, hold, clash, clear
    for (int p = 0; p < 7; p++) cfg[8*p +: 8] = byte_of(2, p[0], 0);
    mute = '0;
    step();
    ovf = 1; step(); ovf = 0;
    repeat (4) step();
    ovf = 1; clr = 1; step();
    ovf = 0; step();
    clr = 1; step(); clr = 0;
    repeat (3) step();
    // R9: request each pin while input or driven
    for (int p = 0; p < 7; p++) cfg[8*p +: 8] = byte_of(p % 2 == 0 ? 0 : 3, 0, 0);
    for (int k = 0; k < 8; k++) begin
      rx_sel = 3'(k); pin_in = 7'(k * 37); rx0 = k[0]; step(); step();
    end
    // mixed phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 16 == 0) cfg = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
      mute   = 8'($urandom);
      ovf    = ($urandom % 23) == 0;
      clr    = ($urandom % 17) == 0;
      pin_in = 7'($urandom);
      rx0    = 1'($urandom);
      rx_sel = 3'($urandom);
      if (i == 1500) rst_n = 0;
      if (i == 1504) rst_n = 1;
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule